// File: doc/BRIEF.md
# Power-of-Two Processor Clock-Enable Divider

This block derives a processor clock from a single fixed master clock by dividing it by a programmable power of two. It does not generate a new clock. It emits a one-master-cycle enable pulse, `cpuEn`, that processor logic running on the master clock uses to qualify its registers. A 3-bit exponent code selects the ratio. Code N divides by 2^N, so the codes 0 to 7 cover ratios from 1 to 128. With a 4.9152 MHz master clock the effective processor rate therefore spans 4.9152 MHz down to 38.4 kHz. After reset the code is 0, and the processor runs at the full master rate.

A second enable, `dbgEn`, runs at twice the processor rate and feeds a debug port. A disable input suppresses it. At code 0 twice the master rate cannot be expressed, so `dbgEn` then saturates and is asserted every cycle.

All timing comes from one free-running 7-bit phase counter. A newly requested code is adopted only when that counter wraps, which is the boundary of the slowest (divide-by-128) period. At that point every ratio is phase-aligned, so no processor period is ever shortened. While the brownout indication is high, the adopted code is frozen. The setting therefore survives a brownout time-base change, and reloading resumes at the first wrap after brownout ends.

Top module: `pwr2ClkDiv`

## Requirements
- R1: While reset is asserted and after it is released, the adopted code is 0. With `dbgOff` low, both `cpuEn` and `dbgEn` are high on every master cycle until another code is adopted.
- R2: With adopted code N, `cpuEn` is high for exactly one master cycle in every 2^N master cycles.
- R3: A phase counter starts at 0 on the first master clock edge after reset release and increments by one per master cycle, wrapping from 127 to 0. `cpuEn` is high exactly when the counter value is a multiple of 2^N.
- R4: For N ≥ 1 and `dbgOff` low, `dbgEn` is high exactly when the counter value is a multiple of 2^(N-1). This is twice the `cpuEn` rate, and `dbgEn` is also high on every `cpuEn` cycle. For N = 0, `dbgEn` is high every cycle.
- R5: While `dbgOff` is high, `dbgEn` is low in that same cycle. `dbgOff` has no effect on `cpuEn`.
- R6: `divCode` is adopted only on the clock edge at which the counter goes from 127 to 0. Between those edges a change of `divCode` leaves the `cpuEn` and `dbgEn` pattern unchanged.
- R7: While `brownout` is high at a wrap edge, the adopted code is kept and `divCode` is ignored. The first wrap edge with `brownout` low adopts the current `divCode`.
- R8: Codes 0, 1, 2, 3, 4, 5, 6 and 7 give the ratios 1, 2, 4, 8, 16, 32, 64 and 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divCode | input | 3 | Requested divide exponent N (ratio 2^N) |
| dbgOff | input | 1 | High suppresses the debug enable |
| brownout | input | 1 | High while in brownout mode; freezes the adopted code |
| cpuEn | output | 1 | Processor clock-enable pulse |
| dbgEn | output | 1 | Debug-port enable at twice the processor rate |

## Verification
Each of the eight codes is held across several full 128-cycle frames. A per-cycle arithmetic model built from counter multiples separates a wrong ratio from a correct ratio at the wrong phase. The code is also changed in the middle of a frame, and the changes must not show until the wrap, which exposes a design that reloads immediately or a shortened period. Toggling `dbgOff` distinguishes gating of the debug enable from any disturbance of `cpuEn`. A code change while `brownout` is high, followed by its release, shows whether the freeze holds across a wrap and whether reloading resumes afterwards.

// File: rtl/pwr2ClkDivPkg.sv
package pwr2ClkDivPkg;

  // Strobes the control side hands to the datapath each master cycle.
  typedef struct packed {
    logic selLoad;   // adopt the requested code at this edge
    logic dbgGate;   // debug enable permitted this cycle
  } divStrobes_t;

  localparam int unsigned DEF_SEL_W = 3;

endpackage

// File: rtl/pwr2DivCtrl.sv
module pwr2DivCtrl
  import pwr2ClkDivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        atWrap,
  input  logic        dbgOff,
  input  logic        brownout,
  output divStrobes_t strb
);

  always_comb begin
    strb.selLoad = atWrap && !brownout;
    strb.dbgGate = !dbgOff;
  end

  // R7: no reload may be requested while in brownout
  p_no_load_brownout_r7: assert property (@(posedge clk) disable iff (!rstN)
    brownout |-> !strb.selLoad);

  // R6: a reload request only ever accompanies the counter wrap
  p_load_at_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.selLoad |-> atWrap);

endmodule

// File: rtl/pwr2DivPath.sv
module pwr2DivPath
  import pwr2ClkDivPkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divCode,
  input  divStrobes_t      strb,
  output logic             atWrap,
  output logic             cpuEn,
  output logic             dbgEn
);

  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] phaseCnt;
  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] cpuMask;
  logic [CNT_W-1:0] dbgMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      activeSel <= '0;
    end else begin
      phaseCnt <= phaseCnt + CNT_W'(1);
      if (strb.selLoad) activeSel <= divCode;
    end
  end

  always_comb begin
    atWrap  = &phaseCnt;
    cpuMask = CNT_W'((32'd1 << activeSel) - 32'd1);
    dbgMask = cpuMask >> 1;
    cpuEn   = ~|(phaseCnt & cpuMask);
    dbgEn   = strb.dbgGate & ~|(phaseCnt & dbgMask);
  end

  // R6: every ratio pulses on the cycle after the wrap, so periods stay whole
  p_wrap_aligns_cpu_r6: assert property (@(posedge clk) disable iff (!rstN)
    atWrap |=> cpuEn);

  // R7: without a load strobe the adopted code stays put
  p_sel_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selLoad |=> $stable(activeSel));

  // R1: at code 0 the processor enable is continuous
  p_full_rate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel == '0) |-> cpuEn);

endmodule

// File: rtl/pwr2ClkDiv.sv
module pwr2ClkDiv
  import pwr2ClkDivPkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divCode,
  input  logic             dbgOff,
  input  logic             brownout,
  output logic             cpuEn,
  output logic             dbgEn
);

  divStrobes_t strb;
  logic        atWrap;

  pwr2DivCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .atWrap   (atWrap),
    .dbgOff   (dbgOff),
    .brownout (brownout),
    .strb     (strb)
  );

  pwr2DivPath #(.SEL_W(SEL_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .divCode (divCode),
    .strb    (strb),
    .atWrap  (atWrap),
    .cpuEn   (cpuEn),
    .dbgEn   (dbgEn)
  );

  // R5: the disable wins in the same cycle
  p_dbg_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    dbgOff |-> !dbgEn);

  // R4: the 2x enable includes every processor pulse
  p_dbg_covers_cpu_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuEn && !dbgOff) |-> dbgEn);

endmodule

// File: tb/tb_pwr2ClkDiv.sv
module tb_pwr2ClkDiv;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] divCode = 3'd0;
  logic       dbgOff = 1'b0;
  logic       brownout = 1'b0;
  logic       cpuEn, dbgEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int refCnt = 0;
  int refSel = 0;
  bit checking = 0;
  string curReq = "R1";

  pwr2ClkDiv dut (
    .clk(clk), .rstN(rstN), .divCode(divCode), .dbgOff(dbgOff),
    .brownout(brownout), .cpuEn(cpuEn), .dbgEn(dbgEn)
  );

  always #2 clk = ~clk;

  // Reference model from the requirements: counter multiples of 2^N.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      refCnt <= 0;
      refSel <= 0;
    end else begin
      refCnt <= (refCnt + 1) % 128;
      if (refCnt == 127 && !brownout) refSel <= int'(divCode);
    end
  end

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b (cnt=%0d code=%0d)",
               req, what, got, exp, refCnt, refSel);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      bit cpuExp, dbgExp;
      cpuExp = (refCnt % (1 << refSel)) == 0;
      if (refSel == 0) dbgExp = !dbgOff;
      else dbgExp = !dbgOff && ((refCnt % (1 << (refSel - 1))) == 0);
      chk(cpuEn, cpuExp, curReq, "cpuEn");
      chk(dbgEn, dbgExp, curReq, "dbgEn");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic runToCnt(input int target);
    while (refCnt != target) step(1);
  endtask

  initial begin
    // R1: reset state, outputs full rate during reset
    step(2);
    @(negedge clk);
    chk(cpuEn, 1'b1, "R1", "cpuEn in reset");
    chk(dbgEn, 1'b1, "R1", "dbgEn in reset");
    @(posedge clk); #1;
    rstN = 1'b1;
    checking = 1;
    curReq = "R1";
    step(200);

    // R2 R3 R4 R8: sweep every code over several frames
    for (int c = 0; c < 8; c++) begin
      curReq = (c == 7) ? "R8" : ((c % 2) == 0 ? "R2" : "R3");
      runToCnt(40);
      divCode = 3'(c);
      step(128 * 3);
    end
    curReq = "R4";
    for (int c = 7; c >= 1; c -= 2) begin
      runToCnt(90);
      divCode = 3'(c);
      step(300);
    end

    // R5: debug disable toggled at several phases and codes
    curReq = "R5";
    for (int c = 0; c < 8; c += 3) begin
      runToCnt(10);
      divCode = 3'(c);
      runToCnt(5);
      dbgOff = 1'b1;
      step(70);
      dbgOff = 1'b0;
      step(33);
      dbgOff = 1'b1;
      step(1);
      dbgOff = 1'b0;
      step(60);
    end

    // R6: mid-frame code changes only show after the wrap
    curReq = "R6";
    runToCnt(20);
    divCode = 3'd0;
    step(200);
    runToCnt(50);
    divCode = 3'd3;
    step(20);
    divCode = 3'd6;
    step(20);
    divCode = 3'd2;
    step(300);
    runToCnt(126);
    divCode = 3'd5;
    step(3);
    divCode = 3'd1;
    step(260);

    // R7: brownout freezes the adopted code across wraps
    curReq = "R7";
    runToCnt(30);
    divCode = 3'd4;
    step(200);
    brownout = 1'b1;
    divCode = 3'd0;
    step(300);
    chk(cpuEn && (refCnt % 16 != 0) ? 1'b1 : 1'b0, 1'b0, "R7", "held ratio");
    runToCnt(60);
    brownout = 1'b0;
    step(300);
    brownout = 1'b1;
    divCode = 3'd7;
    runToCnt(127);
    brownout = 1'b0;
    step(300);

    checking = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule